// File: doc/BRIEF.md
# Serial Trigger-Line Command Decoder

This block sits behind a single-bit serial command line that carries one bit per clock at 40 Mbit/s. The line rests at zero. A command starts with a 1, and the bits that follow that leading 1 decide which command it is.

- A 1 straight after the leading 1 is a calibration request.
- A 0 and then a 1 is a reset command for the downstream components.
- Two zeros make a level-one trigger.

All three commands start with the same bit. The decoder therefore holds its decision until enough bits have arrived, up to two bits past the leading 1. It then raises exactly one single-cycle strobe.

After a command is recognised, the decoder is free again, and the next 1 it samples opens a new command. Two triggers therefore sit at least three bit periods apart, the closest legal pair being 1,0,0,1. Each trigger costs two bit periods of dead time.

The trigger strobe comes two clock cycles after the leading 1. Logic downstream that needs exact trigger timing must take off this fixed latency.

Top module: `trig_line_decoder`

## Requirements
- R1: While the synchronous reset is sampled high, all three strobes are low in the following cycle. The decoder comes out of reset waiting for a leading 1.
- R2: As long as the line is sampled 0 and no command is in progress, no strobe rises.
- R3: Sampled bits 1,0,0 on three successive edges raise `l1a_o` in the cycle after the edge that samples the second 0. That is two edges after the edge of the leading 1.
- R4: Sampled bits 1,0,1 raise `tgt_reset_o` in the cycle after the edge that samples the final 1.
- R5: Sampled bits 1,1 raise `cal_o` in the cycle after the edge that samples the second 1.
- R6: Every strobe is high for exactly one clock cycle per recognised command.
- R7: At most one of the three strobes is high in any cycle.
- R8: The bit that completes a command is not reused. The next sampled 1 starts a fresh command, so 1,0,0,1,0,0 gives two triggers and 1,1,1,1 gives two calibration requests.
- R9: A reset applied in the middle of a command discards the partial bits. Zeros that follow the reset produce no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one line sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Serial command line bit |
| l1a_o | output | 1 | Level-one trigger strobe, one cycle |
| tgt_reset_o | output | 1 | Reset command strobe, one cycle |
| cal_o | output | 1 | Calibration request strobe, one cycle |

## Verification
The hardest situations to reach from the ports are those where the line never rests between commands. In these cases the bit that ends one command is directly followed by the leading 1 of the next one. Examples are a reset immediately followed by a calibration request, and triggers packed at the minimum spacing.

Directed sequences force each of these back-to-back boundaries, and a reset pulse is placed inside a half-received command. A long run of biased random bits then drives the line into mixed command chains. A queue-based reference model predicts every strobe on every cycle.

// File: rtl/tld_pkg.sv
package tld_pkg;

    // Decoder progress through a command
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GOT1  = 2'd1,
        ST_GOT10 = 2'd2
    } tld_state_e;

    // Command recognised on a given edge; value minus one is the strobe index
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_L1A  = 2'd1,
        CMD_RST  = 2'd2,
        CMD_CAL  = 2'd3
    } tld_cmd_e;

    localparam int NUM_STROBES = 3;

    typedef struct packed {
        tld_state_e nxt;
        tld_cmd_e   cmd;
    } tld_step_t;

    // One decode step: current progress plus sampled bit
    function automatic tld_step_t tld_step(input tld_state_e cur, input logic bit_i);
        tld_step_t s;
        s.nxt = ST_IDLE;
        s.cmd = CMD_NONE;
        unique case (cur)
            ST_IDLE:  s.nxt = bit_i ? ST_GOT1 : ST_IDLE;
            ST_GOT1:  begin
                if (bit_i) s.cmd = CMD_CAL;
                else       s.nxt = ST_GOT10;
            end
            ST_GOT10: s.cmd = bit_i ? CMD_RST : CMD_L1A;
            default:  s.nxt = ST_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tld_fsm.sv
module tld_fsm
    import tld_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_i,
    output tld_cmd_e cmd_o
);
    tld_state_e state_q;
    tld_step_t  step;

    always_comb begin
        step  = tld_step(state_q, bit_i);
        cmd_o = step.cmd;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= step.nxt;
    end
endmodule

// File: rtl/tld_strobe_reg.sv
module tld_strobe_reg
    import tld_pkg::*;
#(
    parameter int N = NUM_STROBES
) (
    input  logic         clk,
    input  logic         rst,
    input  tld_cmd_e     cmd_i,
    output logic [N-1:0] strobe_o
);
    localparam int CW = $bits(tld_cmd_e);

    for (genvar i = 0; i < N; i++) begin : g_strobe
        always_ff @(posedge clk) begin
            if (rst) strobe_o[i] <= 1'b0;
            else     strobe_o[i] <= (cmd_i == CW'(i + 1));
        end
    end
endmodule

// File: rtl/trig_line_decoder.sv
module trig_line_decoder
    import tld_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic l1a_o,
    output logic tgt_reset_o,
    output logic cal_o
);
    tld_cmd_e               cmd;
    logic [NUM_STROBES-1:0] strobes;

    tld_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .bit_i (line_i),
        .cmd_o (cmd)
    );

    tld_strobe_reg #(.N(NUM_STROBES)) u_strobes (
        .clk      (clk),
        .rst      (rst),
        .cmd_i    (cmd),
        .strobe_o (strobes)
    );

    assign l1a_o       = strobes[int'(CMD_L1A) - 1];
    assign tgt_reset_o = strobes[int'(CMD_RST) - 1];
    assign cal_o       = strobes[int'(CMD_CAL) - 1];
endmodule

// File: rtl/tld_checker.sv
module tld_checker (
    input logic clk,
    input logic rst,
    input logic line_i,
    input logic l1a_o,
    input logic tgt_reset_o,
    input logic cal_o
);
    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !(l1a_o || tgt_reset_o || cal_o));

    a_r7_one_hot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({l1a_o, tgt_reset_o, cal_o}));

    a_r6_l1a_single: assert property (@(posedge clk) disable iff (rst)
        l1a_o |=> !l1a_o);
    a_r6_rst_single: assert property (@(posedge clk) disable iff (rst)
        tgt_reset_o |=> !tgt_reset_o);
    a_r6_cal_single: assert property (@(posedge clk) disable iff (rst)
        cal_o |=> !cal_o);

    a_r3_trigger_pattern: assert property (@(posedge clk) disable iff (rst)
        l1a_o |-> ($past(line_i, 3) && !$past(line_i, 2) && !$past(line_i, 1)));

    a_r4_reset_pattern: assert property (@(posedge clk) disable iff (rst)
        tgt_reset_o |-> ($past(line_i, 3) && !$past(line_i, 2) && $past(line_i, 1)));

    a_r5_cal_pattern: assert property (@(posedge clk) disable iff (rst)
        cal_o |-> ($past(line_i, 2) && $past(line_i, 1)));
endmodule

bind trig_line_decoder tld_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_i      (line_i),
    .l1a_o       (l1a_o),
    .tgt_reset_o (tgt_reset_o),
    .cal_o       (cal_o)
);

// File: tb/trig_line_decoder_bench.sv
`timescale 1ns/1ps
module trig_line_decoder_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_i = 1'b0;
    logic l1a_o, tgt_reset_o, cal_o;

    int    checks = 0;
    int    errors = 0;
    string req = "R1";
    bit    armed = 0;
    bit    done = 0;
    int    l1a_count = 0;
    int    cal_count = 0;

    always #2 clk = ~clk;

    trig_line_decoder u_trig_line_decoder (
        .clk(clk), .rst(rst), .line_i(line_i),
        .l1a_o(l1a_o), .tgt_reset_o(tgt_reset_o), .cal_o(cal_o)
    );

    // Reference model: collect bits from a leading 1 until a command is complete
    logic pend[$];
    logic e_l1a = 0, e_rst = 0, e_cal = 0;

    always @(posedge clk) begin
        armed <= 1;
        if (rst) begin
            pend.delete();
            e_l1a <= 0; e_rst <= 0; e_cal <= 0;
        end else begin
            logic n_l1a, n_rst, n_cal;
            n_l1a = 0; n_rst = 0; n_cal = 0;
            if (pend.size() > 0 || line_i) pend.push_back(line_i);
            if (pend.size() == 2 && pend[1]) begin
                n_cal = 1; pend.delete();
            end else if (pend.size() == 3) begin
                if (pend[2]) n_rst = 1; else n_l1a = 1;
                pend.delete();
            end
            e_l1a <= n_l1a; e_rst <= n_rst; e_cal <= n_cal;
        end
    end

    // Compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if ({l1a_o, tgt_reset_o, cal_o} !== {e_l1a, e_rst, e_cal}) begin
                errors++;
                $display("FAIL %s: strobes l1a/rst/cal actual %b%b%b expected %b%b%b at %0t",
                         req, l1a_o, tgt_reset_o, cal_o, e_l1a, e_rst, e_cal, $time);
            end
            if (l1a_o === 1'b1) l1a_count++;
            if (cal_o === 1'b1) cal_count++;
        end
    end

    task automatic send(input logic b);
        @(negedge clk);
        line_i = b;
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) send(1'b0);
    endtask

    task automatic check_count(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: pulse count actual %0d expected %0d", r, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is applied
        checks++;
        if ({l1a_o, tgt_reset_o, cal_o} !== 3'b000) begin
            errors++;
            $display("FAIL R1: strobes actual %b%b%b expected 000", l1a_o, tgt_reset_o, cal_o);
        end
        rst = 0;

        req = "R2"; quiet(20);
        req = "R3"; send(1); send(0); send(0); quiet(4);
        req = "R4"; send(1); send(0); send(1); quiet(4);
        req = "R5"; send(1); send(1); quiet(4);

        req = "R8";
        l1a_count = 0;
        send(1); send(0); send(0); send(1); send(0); send(0); send(1); send(0); send(0);
        quiet(3);
        check_count("R8", l1a_count, 3);
        cal_count = 0;
        send(1); send(1); send(1); send(1); quiet(3);
        check_count("R8", cal_count, 2);
        send(1); send(0); send(1); send(1); send(1); quiet(3);
        send(1); send(1); send(1); send(0); send(0); quiet(3);

        req = "R9";
        l1a_count = 0;
        send(1);
        @(negedge clk); rst = 1; line_i = 0;
        @(negedge clk); rst = 0;
        quiet(5);
        check_count("R9", l1a_count, 0);
        send(1); send(0);
        @(negedge clk); rst = 1; line_i = 0;
        @(negedge clk); rst = 0;
        quiet(5);
        check_count("R9", l1a_count, 0);

        req = "R6 R7";
        for (int i = 0; i < 2000; i++) send(($urandom_range(0, 2) == 0) ? 1'b1 : 1'b0);
        for (int i = 0; i < 1000; i++) send(($urandom_range(0, 2) != 0) ? 1'b1 : 1'b0);
        quiet(5);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule